// File: doc/BRIEF.md
# Masked Group Barrier Synchronizer

This block coordinates barrier synchronization among `N` processing nodes. Each node keeps a one-bit progress status that it flips each time it reaches a barrier. That status is broadcast to every node over a fixed-latency network, and every node confirms receipt of it after a further fixed delay. A node's membership register lists the nodes in its group. The node's barrier completes once every listed node shows the same status as the node itself, both at the receivers and in the returned acknowledge.

Nodes whose membership registers describe disjoint sets form independent groups, and those groups complete their barriers without affecting one another. The broadcast and acknowledge delays are parameters, so the same block can model networks of different depth.

A node signals arrival with a one-cycle strobe and a status value. It is released by a one-cycle pulse. A membership register that leaves out its own node is reported as a configuration error.

Top module: `mask_barrier_sync`

## Requirements
- R1: After a synchronous active-low reset, every membership register holds all ones (one group containing every node), every status is 0, no node is waiting, `barrier_done` is all zeros and `cfg_err` is all zeros.
- R2: When the last member of a group arrives in the cycle in which its strobe is sampled, `barrier_done` goes high for the group's members exactly `BCAST_LAT + ACK_LAT + 1` clock edges after that edge. This holds only if every member is showing the same status.
- R3: A waiting node is not released while any node in its membership register shows a status different from its own. This includes a member that has not yet arrived for the current episode and so still shows its previous status.
- R4: Release additionally waits for the acknowledge path. `barrier_done` stays low during the `BCAST_LAT + ACK_LAT` cycles that follow the last arrival.
- R5: Nodes whose membership registers form disjoint sets release independently, each set on its own timing.
- R6: The status of a node that is not set in a waiting node's membership register has no effect on that node's release.
- R7: If bit `i` of node `i`'s membership register is 0, `cfg_err[i]` is 1 and node `i` never pulses `barrier_done[i]`. Other nodes that list it still release once its status matches.
- R8: A membership write to a waiting node does not affect the barrier in progress. It is held and takes effect at the edge that releases that node, and the node's next barrier uses it.
- R9: A membership write to a node that is not waiting takes effect at that clock edge. Node `i`'s new value is `mask_wdata[i*N +: N]`, where bit `j` set means node `j` is a member.
- R10: An arrive strobe to a node that is already waiting is ignored; the status stored at its first arrival is kept.
- R11: `barrier_done[i]` is a single-cycle pulse. After it, node `i` is idle and needs a new arrive strobe before it can release again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| arrive | input | N | Per-node arrival strobe, one cycle |
| arrive_status | input | N | Per-node progress status sampled with `arrive` |
| mask_we | input | N | Per-node membership register write enable |
| mask_wdata | input | N*N | Write data; node i uses bits [i*N +: N] |
| barrier_done | output | N | Per-node one-cycle release pulse |
| cfg_err | output | N | Per-node flag: membership excludes the node itself |

## Verification
The hardest situation to reach is a membership write that lands while its node is waiting. The held value must survive until the release and then take over, and meanwhile the rest of the group goes on under the old membership. A directed sequence parks one node at a barrier, shrinks its membership to itself, and keeps its partner away for several cycles to show the write had no effect yet. It then shows the node releasing alone on its next episode. The random phase also overlaps writes and arrivals with barriers in flight, which produces short-lived asymmetric memberships. A cycle-level reference model in the bench follows these.

// File: rtl/bsync_pkg.sv
// Shared definitions for the masked group barrier synchronizer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package bsync_pkg;

    // Per-node barrier state: idle, or parked at a barrier.
    typedef enum logic {
        NODE_IDLE = 1'b0,
        NODE_WAIT = 1'b1
    } node_state_e;

endpackage

// File: rtl/bsync_delay_line.sv
// Fixed-latency pipeline of WIDTH-bit words, DEPTH registers deep.
// Models the status broadcast network and the acknowledge return path.
// Assumes: synchronous active-low reset clears every stage to zero;
// DEPTH of zero degenerates to a wire.
module bsync_delay_line #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_regs
            logic [WIDTH-1:0] stage_q [DEPTH];

            // Shift the word one stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int k = 0; k < DEPTH; k++) stage_q[k] <= '0;
                end else begin
                    stage_q[0] <= din;
                    for (int k = 1; k < DEPTH; k++) stage_q[k] <= stage_q[k-1];
                end
            end

            assign dout = stage_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/bsync_match.sv
// Group readiness test for one node: every member must show the node's
// own status both at the receivers and in the returned acknowledge.
// Assumes: rx and ack vectors are indexed by node number.
module bsync_match #(
    parameter int N = 4
) (
    input  logic [N-1:0] member,
    input  logic         own,
    input  logic [N-1:0] rx_status,
    input  logic [N-1:0] ack_status,
    output logic         ready
);

    logic [N-1:0] bit_ok;

    generate
        for (genvar j = 0; j < N; j++) begin : g_bit
            // A non-member always passes; a member must match on both paths.
            assign bit_ok[j] = !member[j] ||
                               ((rx_status[j] == own) && (ack_status[j] == own));
        end
    endgenerate

    assign ready = &bit_ok;

endmodule

// File: rtl/bsync_node.sv
// Per-node barrier controller: stores the node's status at arrival,
// holds its membership register (with a deferred write slot used while
// waiting), and pulses done when its group is ready.
// Assumes: rx/ack vectors come from the shared delay lines; a node whose
// membership omits itself is flagged and never released.
module bsync_node
    import bsync_pkg::*;
#(
    parameter int N   = 4,
    parameter int IDX = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arrive_i,
    input  logic         arrive_status_i,
    input  logic         mask_we_i,
    input  logic [N-1:0] mask_wdata_i,
    input  logic [N-1:0] rx_status_i,
    input  logic [N-1:0] ack_status_i,
    output logic         own_status_o,
    output logic         done_o,
    output logic         cfg_err_o
);

    localparam logic [N-1:0] MASK_AT_RESET = {N{1'b1}};

    node_state_e  state_q;
    logic         own_q;
    logic [N-1:0] mask_q;
    logic [N-1:0] pend_q;
    logic         pend_v_q;
    logic         done_q;
    logic         grp_ready;
    logic         waiting;
    logic         can_go;

    bsync_match #(.N(N)) u_match (
        .member     (mask_q),
        .own        (own_q),
        .rx_status  (rx_status_i),
        .ack_status (ack_status_i),
        .ready      (grp_ready)
    );

    assign waiting = (state_q == NODE_WAIT);
    assign can_go  = waiting && mask_q[IDX] && grp_ready;

    // Barrier state, stored status, membership and release pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= NODE_IDLE;
            own_q    <= 1'b0;
            mask_q   <= MASK_AT_RESET;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= can_go;
            if (!waiting) begin
                if (mask_we_i) mask_q <= mask_wdata_i;
                pend_v_q <= 1'b0;
                if (arrive_i) begin
                    state_q <= NODE_WAIT;
                    own_q   <= arrive_status_i;
                end
            end else if (can_go) begin
                state_q  <= NODE_IDLE;
                pend_v_q <= 1'b0;
                if (mask_we_i)     mask_q <= mask_wdata_i;
                else if (pend_v_q) mask_q <= pend_q;
            end else if (mask_we_i) begin
                pend_q   <= mask_wdata_i;
                pend_v_q <= 1'b1;
            end
        end
    end

    assign own_status_o = own_q;
    assign done_o       = done_q;
    assign cfg_err_o    = !mask_q[IDX];

    // R11: release is a single-cycle pulse.
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R7: a release only follows a cycle in which the node listed itself.
    assert_self_member_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(mask_q[IDX]));

    // R8: membership is frozen across consecutive waiting cycles.
    assert_mask_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && $past(waiting)) |-> $stable(mask_q));

    // R10: a repeated arrival does not disturb the stored status.
    assert_status_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && $past(waiting)) |-> $stable(own_q));

endmodule

// File: rtl/mask_barrier_sync.sv
// Masked group barrier synchronizer for N nodes. Each node's status is
// broadcast over a BCAST_LAT-cycle network; receipt is confirmed over a
// further ACK_LAT cycles. Nodes release when all group members match.
// Assumes: nodes flip their status at each barrier episode.
module mask_barrier_sync #(
    parameter int N         = 4,
    parameter int BCAST_LAT = 2,
    parameter int ACK_LAT   = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   arrive,
    input  logic [N-1:0]   arrive_status,
    input  logic [N-1:0]   mask_we,
    input  logic [N*N-1:0] mask_wdata,
    output logic [N-1:0]   barrier_done,
    output logic [N-1:0]   cfg_err
);

    logic [N-1:0] own_status;
    logic [N-1:0] rx_status;
    logic [N-1:0] ack_status;

    bsync_delay_line #(.WIDTH(N), .DEPTH(BCAST_LAT)) u_bcast (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (own_status),
        .dout  (rx_status)
    );

    bsync_delay_line #(.WIDTH(N), .DEPTH(ACK_LAT)) u_ack (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_status),
        .dout  (ack_status)
    );

    generate
        for (genvar i = 0; i < N; i++) begin : g_node
            bsync_node #(.N(N), .IDX(i)) u_node (
                .clk             (clk),
                .rst_n           (rst_n),
                .arrive_i        (arrive[i]),
                .arrive_status_i (arrive_status[i]),
                .mask_we_i       (mask_we[i]),
                .mask_wdata_i    (mask_wdata[i*N +: N]),
                .rx_status_i     (rx_status),
                .ack_status_i    (ack_status),
                .own_status_o    (own_status[i]),
                .done_o          (barrier_done[i]),
                .cfg_err_o       (cfg_err[i])
            );

            // R4: a release follows a cycle where the node's own
            // acknowledged status already equalled its stored status.
            assert_ack_before_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
                barrier_done[i] |-> $past(ack_status[i] == own_status[i]));
        end
    endgenerate

endmodule

// File: tb/mask_barrier_sync_bench.sv
`timescale 1ns/1ps
module mask_barrier_sync_bench;

    localparam int N   = 4;
    localparam int BL  = 2;
    localparam int AL  = 1;
    localparam int LAT = BL + AL + 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   arrive = '0;
    logic [N-1:0]   arrive_status = '0;
    logic [N-1:0]   mask_we = '0;
    logic [N*N-1:0] mask_wdata = '0;
    logic [N-1:0]   barrier_done;
    logic [N-1:0]   cfg_err;

    mask_barrier_sync #(.N(N), .BCAST_LAT(BL), .ACK_LAT(AL)) u_mask_barrier_sync (
        .clk           (clk),
        .rst_n         (rst_n),
        .arrive        (arrive),
        .arrive_status (arrive_status),
        .mask_we       (mask_we),
        .mask_wdata    (mask_wdata),
        .barrier_done  (barrier_done),
        .cfg_err       (cfg_err)
    );

    always #4 clk = ~clk;

    int    checks = 0;
    int    fails = 0;
    string cur_req = "R1";

    // Reference model state.
    logic [N-1:0] m_wait, m_own, m_rel, m_pv;
    logic [N-1:0] m_mask [N];
    logic [N-1:0] m_pend [N];
    logic [N-1:0] bpipe [BL];
    logic [N-1:0] apipe [AL];

    function automatic logic grp_ok(int i);
        logic ok = m_wait[i] && m_mask[i][i];
        for (int j = 0; j < N; j++)
            if (m_mask[i][j] && (bpipe[BL-1][j] != m_own[i] || apipe[AL-1][j] != m_own[i]))
                ok = 1'b0;
        return ok;
    endfunction

    function automatic logic [N-1:0] exp_cfg();
        logic [N-1:0] e;
        for (int i = 0; i < N; i++) e[i] = !m_mask[i][i];
        return e;
    endfunction

    task automatic model_reset();
        m_wait = '0; m_own = '0; m_rel = '0; m_pv = '0;
        for (int i = 0; i < N; i++) begin m_mask[i] = '1; m_pend[i] = '0; end
        for (int k = 0; k < BL; k++) bpipe[k] = '0;
        for (int k = 0; k < AL; k++) apipe[k] = '0;
    endtask

    task automatic model_adv();
        logic [N-1:0] cond, old_own, new_own, b_last, wd;
        b_last  = bpipe[BL-1];
        old_own = m_own;
        new_own = m_own;
        for (int i = 0; i < N; i++) cond[i] = grp_ok(i);
        for (int i = 0; i < N; i++) begin
            wd = mask_wdata[i*N +: N];
            if (!m_wait[i]) begin
                if (mask_we[i]) m_mask[i] = wd;
                m_pv[i] = 1'b0;
                if (arrive[i]) begin m_wait[i] = 1'b1; new_own[i] = arrive_status[i]; end
            end else if (cond[i]) begin
                if (mask_we[i]) m_mask[i] = wd;
                else if (m_pv[i]) m_mask[i] = m_pend[i];
                m_pv[i] = 1'b0;
                m_wait[i] = 1'b0;
            end else if (mask_we[i]) begin
                m_pend[i] = wd;
                m_pv[i] = 1'b1;
            end
        end
        for (int k = AL-1; k >= 1; k--) apipe[k] = apipe[k-1];
        apipe[0] = b_last;
        for (int k = BL-1; k >= 1; k--) bpipe[k] = bpipe[k-1];
        bpipe[0] = old_own;
        m_own = new_own;
        m_rel = cond;
    endtask

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        check(barrier_done === m_rel, cur_req, "barrier_done vs model", barrier_done, m_rel);
        check(cfg_err === exp_cfg(), cur_req, "cfg_err vs model", cfg_err, exp_cfg());
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        model_adv();
        compare();
        arrive  = '0;
        mask_we = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        arrive = '0; mask_we = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic go(logic [N-1:0] who);
        arrive = who;
        for (int i = 0; i < N; i++) if (who[i]) arrive_status[i] = ~m_own[i];
    endtask

    task automatic wr(int i, logic [N-1:0] m);
        mask_we[i] = 1'b1;
        mask_wdata[i*N +: N] = m;
    endtask

    task automatic expect_done(logic [N-1:0] exp, string req);
        check(barrier_done === exp, req, "barrier_done", barrier_done, exp);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [1:0] gid [N];
        logic [N-1:0] gm;
        void'($urandom(32'd20250));
        do_reset();

        // R1: reset state
        cur_req = "R1";
        expect_done('0, "R1");
        check(cfg_err === '0, "R1", "cfg_err after reset", cfg_err, '0);

        // R2 R4 R11: whole-system barrier, simultaneous arrival
        cur_req = "R2";
        go('1); tick();
        repeat (LAT-1) begin tick(); expect_done('0, "R4"); end
        tick(); expect_done('1, "R2");
        tick(); expect_done('0, "R11");

        // R2: staggered arrival, timing from the last one
        go(4'b0001); tick(); tick();
        go(4'b0110); tick(); tick();
        go(4'b1000); tick();
        repeat (LAT-1) begin tick(); expect_done('0, "R4"); end
        tick(); expect_done('1, "R2");
        tick();

        // R3: a member still showing the old status blocks release
        cur_req = "R3";
        go(4'b0111); tick();
        repeat (10) tick();
        expect_done('0, "R3");
        go(4'b1000); tick();
        repeat (LAT-1) tick();
        expect_done('0, "R3");
        tick(); expect_done('1, "R3");
        tick();

        // R9 R5 R6: two disjoint pairs, written while idle
        cur_req = "R5";
        wr(0, 4'b0011); wr(1, 4'b0011); wr(2, 4'b1100); wr(3, 4'b1100);
        tick();
        check(cfg_err === '0, "R9", "cfg_err after pair write", cfg_err, '0);
        go(4'b0011); tick();
        repeat (LAT) tick();
        expect_done(4'b0011, "R6");
        tick();
        go(4'b1100); tick();
        repeat (LAT) tick();
        expect_done(4'b1100, "R5");
        tick();

        // R8: membership write while waiting is deferred
        cur_req = "R8";
        go(4'b0001); tick();
        wr(0, 4'b0001); tick();
        repeat (8) tick();
        expect_done('0, "R8");
        go(4'b0010); tick();
        repeat (LAT) tick();
        expect_done(4'b0011, "R8");
        tick();
        go(4'b0001); tick();
        repeat (LAT) tick();
        expect_done(4'b0001, "R8");
        tick();

        // R7: a node leaving itself out is flagged and never released
        cur_req = "R7";
        wr(2, 4'b1000); tick();
        check(cfg_err === 4'b0100, "R7", "cfg_err self excluded", cfg_err, 4'b0100);
        go(4'b1100); tick();
        repeat (LAT) tick();
        expect_done(4'b1000, "R7");
        repeat (6) begin
            tick();
            check(barrier_done[2] === 1'b0, "R7", "flagged node released", barrier_done, '0);
        end
        do_reset();
        compare();

        // R10: second arrival while waiting is ignored
        cur_req = "R10";
        go(4'b0001); tick();
        arrive = 4'b0001; arrive_status = 4'b0000; tick();
        go(4'b1110); tick();
        repeat (LAT) tick();
        expect_done('1, "R10");
        tick();

        // R5: random traffic with repartitioning and overlapping writes
        cur_req = "R5";
        for (int t = 0; t < 4000; t++) begin
            if (m_wait == '0 && $urandom_range(0, 19) == 0) begin
                for (int i = 0; i < N; i++) gid[i] = 2'($urandom_range(0, 2));
                for (int i = 0; i < N; i++) begin
                    gm = '0;
                    for (int j = 0; j < N; j++) gm[j] = (gid[j] == gid[i]);
                    wr(i, gm);
                end
            end else if ($urandom_range(0, 49) == 0) begin
                wr(int'($urandom_range(0, N-1)), '1);
            end
            for (int i = 0; i < N; i++) begin
                if (!m_wait[i] && $urandom_range(0, 3) == 0) begin
                    arrive[i] = 1'b1; arrive_status[i] = ~m_own[i];
                end else if (m_wait[i] && $urandom_range(0, 15) == 0) begin
                    arrive[i] = 1'b1; arrive_status[i] = 1'($urandom_range(0, 1));
                end
            end
            tick();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule